// File: doc/BRIEF.md
# Half-Step Clock Pre-Divider

This block sits between a selected source clock and a later fractional rate stage. It divides the source clock by a ratio of (F + 1) / 2, where F is an unsigned divide field. The ratio therefore moves in steps of one half. An odd F gives a whole-number ratio and the block runs on rising edges only. An even F of two or more gives a ratio ending in one half, and the block also uses the falling edge of the source clock. F equal to 0 or 1 passes the source clock straight through.

The block counts in half-periods of the source clock. A register updated on the falling edge sets the output level for each coming high half of the source clock. A register updated on the rising edge sets the level for each coming low half. The output is then a select between the two levels, driven by the source clock itself. Each selected level is stable for the whole half in which it is used.

A new field is written by pulsing a load strobe. The block keeps the value as pending. It switches to the new value only where an output period begins on a rising edge, so the output period in progress always finishes with its old shape.

Top module: `hdiv_top`

## Requirements
- R1: While `rst_n` is low, `clk_out` is low and the active field is 0. In the high half that follows the first rising edge after release, `clk_out` stays low. From the second rising edge on, `clk_out` follows the active field.
- R2: An active field of 0 or 1 gives bypass: `clk_out` is high during every high half of `clk_in` and low during every low half.
- R3: An odd active field F of 3 or more gives an output period of F + 1 half-periods, i.e. (F + 1) / 2 whole input cycles. Let P = F + 1. The output is high for 2 * floor(P / 4) half-periods at the start of each period.
- R4: An even active field F of 2 or more gives an output period of F + 1 half-periods, i.e. a ratio of F / 2 + 1/2. The output is high for the first F / 2 half-periods of each period and low for the remaining F / 2 + 1.
- R5: With an odd active field, every output transition falls on a rising edge of `clk_in`. The level in each low half equals the level in the high half before it.
- R6: A field captured by `load` at a rising edge is adopted at the first later rising edge where an output period starts. The new period begins with its high phase, and the period that was running finishes unchanged.
- R7: A second `load` before adoption replaces the pending value. Only the latest value is adopted.
- R8: The all-ones field (2^FW − 1) gives the largest ratio, 2^(FW−1), with a high time of 2 * floor(2^FW / 4) half-periods.
- R9: Changes on `div_in` while `load` is low do not change the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Source clock to be divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Strobe that captures `div_in`, sampled on the rising edge |
| div_in | input | FW | Divide field F; the ratio is (F+1)/2, and 0 or 1 means bypass |
| clk_out | output | 1 | Divided clock |

## Verification
The two functions that can fall in the same cycle are the capture of a load strobe and a phase wrap that opens a period on a rising edge. Two cases are provoked: a second strobe lands one cycle after the first, while a long period is still running, and random strobes arrive at every phase offset of odd-length periods. A bench-side half-period model is compared against the output level sampled in the middle of every high half and every low half. A strobe captured too early, or a boundary missed, shows up as a wrong level in some half.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;

  typedef enum logic [1:0] {
    HD_BYPASS = 2'd0,
    HD_WHOLE  = 2'd1,
    HD_HALF   = 2'd2
  } hd_mode_e;

  // Output period in half-periods of the source clock.
  function automatic logic [31:0] hd_period(input logic [31:0] f);
    return (f <= 32'd1) ? 32'd2 : f + 32'd1;
  endfunction

  // Number of leading half-periods for which the output is high.
  function automatic logic [31:0] hd_high(input logic [31:0] p);
    if (p == 32'd2)
      return 32'd1;
    else if (p[0])
      return p >> 1;
    else
      return (p >> 2) << 1;
  endfunction

  // Phase advance modulo the period; inc never exceeds the period.
  function automatic logic [31:0] hd_step(input logic [31:0] ph,
                                          input logic [31:0] p,
                                          input logic [31:0] inc);
    logic [31:0] s;
    s = ph + inc;
    return (s >= p) ? s - p : s;
  endfunction

  function automatic hd_mode_e hd_mode(input logic [31:0] f);
    if (f <= 32'd1)
      return HD_BYPASS;
    else if (f[0])
      return HD_WHOLE;
    else
      return HD_HALF;
  endfunction

endpackage

// File: rtl/hdiv_load_latch.sv
module hdiv_load_latch #(
  parameter int FW = 4
) (
  input  logic          clk_in,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] div_in,
  input  logic          ack_i,
  output logic          req_o,
  output logic          pend_o,
  output logic [FW-1:0] val_o
);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      req_o <= 1'b0;
      val_o <= '0;
    end else if (load) begin
      val_o <= div_in;
      req_o <= ~ack_i;
    end
  end

  assign pend_o = req_o ^ ack_i;

endmodule

// File: rtl/hdiv_phase_seq.sv
module hdiv_phase_seq #(
  parameter int FW = 4,
  parameter int PW = FW + 1
) (
  input  logic          clk_in,
  input  logic          rst_n,
  input  logic          pend_i,
  input  logic          req_i,
  input  logic [FW-1:0] pend_val_i,
  output logic          ack_o,
  output logic [PW-1:0] ph_o,
  output logic [FW-1:0] act_o,
  output logic          adopt_o,
  output logic          hi_o
);
  import hdiv_pkg::*;

  logic [PW-1:0] period_w;
  logic [PW-1:0] nxt_ph_w;
  logic [FW-1:0] nxt_act_w;
  logic [PW-1:0] nxt_period_w;
  logic [PW-1:0] nxt_high_w;
  logic [PW-1:0] ph_d;

  assign period_w     = PW'(hd_period(32'(act_o)));
  assign nxt_ph_w     = PW'(hd_step(32'(ph_o), 32'(period_w), 32'd2));
  assign adopt_o      = pend_i && (nxt_ph_w == '0);
  assign nxt_act_w    = adopt_o ? pend_val_i : act_o;
  assign ph_d         = adopt_o ? '0 : nxt_ph_w;
  assign nxt_period_w = PW'(hd_period(32'(nxt_act_w)));
  assign nxt_high_w   = PW'(hd_high(32'(nxt_period_w)));

  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      ph_o  <= '0;
      act_o <= '0;
      ack_o <= 1'b0;
      hi_o  <= 1'b0;
    end else begin
      ph_o  <= ph_d;
      act_o <= nxt_act_w;
      hi_o  <= (ph_d < nxt_high_w);
      if (adopt_o)
        ack_o <= req_i;
    end
  end

endmodule

// File: rtl/hdiv_low_gen.sv
module hdiv_low_gen #(
  parameter int FW = 4,
  parameter int PW = FW + 1
) (
  input  logic          clk_in,
  input  logic          rst_n,
  input  logic [PW-1:0] ph_i,
  input  logic [FW-1:0] act_i,
  output logic          lo_o
);
  import hdiv_pkg::*;

  logic [PW-1:0] period_w;
  logic [PW-1:0] high_w;
  logic [PW-1:0] low_ph_w;

  assign period_w = PW'(hd_period(32'(act_i)));
  assign high_w   = PW'(hd_high(32'(period_w)));
  assign low_ph_w = PW'(hd_step(32'(ph_i), 32'(period_w), 32'd1));

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)
      lo_o <= 1'b0;
    else
      lo_o <= (low_ph_w < high_w);
  end

endmodule

// File: rtl/hdiv_top.sv
module hdiv_top #(
  parameter int FW = 4,
  localparam int PW = FW + 1
) (
  input  logic          clk_in,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] div_in,
  output logic          clk_out
);
  import hdiv_pkg::*;

  logic          req_w;
  logic          ack_w;
  logic          pend_w;
  logic [FW-1:0] pend_val_w;
  logic [PW-1:0] ph_w;
  logic [FW-1:0] act_w;
  logic          adopt_w;
  logic          hi_w;
  logic          lo_w;
  hd_mode_e      mode_w;

  hdiv_load_latch #(.FW(FW)) u_latch (
    .clk_in (clk_in),
    .rst_n  (rst_n),
    .load   (load),
    .div_in (div_in),
    .ack_i  (ack_w),
    .req_o  (req_w),
    .pend_o (pend_w),
    .val_o  (pend_val_w)
  );

  hdiv_phase_seq #(.FW(FW), .PW(PW)) u_seq (
    .clk_in     (clk_in),
    .rst_n      (rst_n),
    .pend_i     (pend_w),
    .req_i      (req_w),
    .pend_val_i (pend_val_w),
    .ack_o      (ack_w),
    .ph_o       (ph_w),
    .act_o      (act_w),
    .adopt_o    (adopt_w),
    .hi_o       (hi_w)
  );

  hdiv_low_gen #(.FW(FW), .PW(PW)) u_low (
    .clk_in (clk_in),
    .rst_n  (rst_n),
    .ph_i   (ph_w),
    .act_i  (act_w),
    .lo_o   (lo_w)
  );

  assign mode_w  = hd_mode(32'(act_w));
  // Each level is updated only in the opposite half of clk_in.
  assign clk_out = clk_in ? hi_w : lo_w;

endmodule

// File: rtl/hdiv_checker.sv
module hdiv_checker #(
  parameter int FW = 4,
  parameter int PW = FW + 1
) (
  input logic               clk_in,
  input logic               rst_n,
  input logic [PW-1:0]      ph_w,
  input logic [FW-1:0]      act_w,
  input logic               adopt_w,
  input logic               hi_w,
  input logic               lo_w,
  input hdiv_pkg::hd_mode_e mode_w
);
  import hdiv_pkg::*;

  logic [PW-1:0] period_c;
  assign period_c = PW'(hd_period(32'(act_w)));

  a_r3_phase_in_range: assert property (@(negedge clk_in) disable iff (!rst_n)
    ph_w < period_c);

  a_r6_field_only_on_adopt: assert property (@(negedge clk_in) disable iff (!rst_n)
    !adopt_w |=> $stable(act_w));

  a_r6_adopt_starts_period: assert property (@(negedge clk_in) disable iff (!rst_n)
    adopt_w |=> (ph_w == '0) && hi_w);

  a_r2_bypass_phase_zero: assert property (@(negedge clk_in) disable iff (!rst_n)
    (mode_w == HD_BYPASS) |-> (ph_w == '0));

  a_r5_whole_phase_even: assert property (@(negedge clk_in) disable iff (!rst_n)
    (mode_w != HD_HALF) |-> !ph_w[0]);

  a_r5_low_matches_high: assert property (@(negedge clk_in) disable iff (!rst_n)
    (mode_w == HD_WHOLE) |-> (lo_w == hi_w));

endmodule

bind hdiv_top hdiv_checker #(.FW(FW), .PW(PW)) u_chk (
  .clk_in  (clk_in),
  .rst_n   (rst_n),
  .ph_w    (ph_w),
  .act_w   (act_w),
  .adopt_w (adopt_w),
  .hi_w    (hi_w),
  .lo_w    (lo_w),
  .mode_w  (mode_w)
);

// File: tb/tb_hdiv_top.sv
`timescale 1ns/1ps
module tb_hdiv_top;
  localparam int FW   = 4;
  localparam int FMAX = (1 << FW) - 1;

  logic          clk_in = 1'b0;
  logic          rst_n  = 1'b0;
  logic          load   = 1'b0;
  logic [FW-1:0] div_in = '0;
  wire           clk_out;

  always #4 clk_in = ~clk_in;

  hdiv_top #(.FW(FW)) dut (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .load    (load),
    .div_in  (div_in),
    .clk_out (clk_out)
  );

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  bit    done   = 1'b0;
  int    m_ph   = 0;
  int    m_act  = 0;
  int    m_pv   = 0;
  bit    m_pend = 1'b0;
  string seg    = "";

  // Half-periods per output period.
  function automatic int m_period(int f);
    if (f < 2) return 2;
    return f + 1;
  endfunction

  // High half-periods: bypass 1; half-step F/2; whole ratio rounded down to full cycles.
  function automatic int m_high(int p);
    int half;
    if (p == 2) return 1;
    if (p % 2 == 1) return (p - 1) / 2;
    half = p / 2;
    return half - (half % 2);
  endfunction

  function automatic string m_tag(int f);
    if (f == FMAX) return "R8";
    if (f < 2) return "R2";
    if (f % 2 == 1) return "R3/R5";
    return "R4";
  endfunction

  task automatic check(bit got, bit exp, string tag, string half);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s half of cycle %0d: got %0b expected %0b (field %0d)",
               tag, half, cyc, got, exp, m_act);
    end
  endtask

  task automatic model_step(bit first);
    int p, nx;
    if (!first) begin
      p  = m_period(m_act);
      nx = (m_ph + 2) % p;
      if (m_pend && nx == 0) begin
        m_act  = m_pv;
        m_ph   = 0;
        m_pend = 1'b0;
      end else begin
        m_ph = nx;
      end
    end
    if (load) begin
      m_pend = 1'b1;
      m_pv   = int'(div_in);
    end
  endtask

  task automatic cycle(bit first, bit nld, int ndv);
    int p, h;
    bit eh, el;
    string tag;
    @(posedge clk_in);
    model_step(first);
    p   = m_period(m_act);
    h   = m_high(p);
    eh  = first ? 1'b0 : (m_ph < h);
    el  = (((m_ph + 1) % p) < h);
    tag = (seg != "") ? seg : m_tag(m_act);
    #2 check(clk_out, eh, first ? "R1" : tag, "high");
    @(negedge clk_in);
    #2 check(clk_out, el, tag, "low");
    load   = nld;
    div_in = FW'(ndv);
    cyc++;
  endtask

  task automatic run(int n, int f);
    cycle(1'b0, 1'b1, f);
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, f);
  endtask

  initial begin
    int r;
    r = int'($urandom(32'd20240611));
    for (int i = 0; i < 3; i++) begin
      @(posedge clk_in); #2 check(clk_out, 1'b0, "R1", "high");
      @(negedge clk_in); #2 check(clk_out, 1'b0, "R1", "low");
    end
    rst_n = 1'b1;
    cycle(1'b1, 1'b0, 0);
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, 0);

    run(8, 0);  run(8, 1);
    run(12, 3); run(12, 2);
    run(20, 4); run(20, 5);
    run(40, FMAX); run(30, 14);

    seg = "R6";
    run(40, 6); run(30, 9); run(30, 2);
    seg = "";
    run(20, 13);

    seg = "R7";
    cycle(1'b0, 1'b1, 3);
    cycle(1'b0, 1'b1, 9);
    for (int i = 0; i < 40; i++) cycle(1'b0, 1'b0, 9);

    seg = "";
    run(12, 6);
    seg = "R9";
    for (int i = 0; i < 30; i++) cycle(1'b0, 1'b0, int'($urandom % (FMAX + 1)));
    seg = "";

    for (int i = 0; i < 1500; i++) begin
      int sel, dv;
      sel = int'($urandom % 8);
      if (sel == 0) dv = 0;
      else if (sel == 1) dv = FMAX;
      else dv = int'($urandom % (FMAX + 1));
      cycle(1'b0, ($urandom % 12) == 0, dv);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): got no completion, expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule